// File: doc/BRIEF.md
# SPI Write Waveform Pattern Generator

This block converts a write request into a stream of parallel pattern words, one word for every cycle of the pattern clock. Each word carries the three wires of a serial peripheral interface master on chosen bit positions of an 8-bit output lane. The three wires are slave select (active low), serial clock and master-out data. The pattern stream can be played straight out of a digital output card, or stored as a trace for later playback. Only writes are built. No return data is captured.

A transaction is requested with a one-cycle start strobe. The request carries a payload, a bit count and the index of the target slave. The line-placement fields choose which output bit carries which wire. Every slave has its own select bit, so several slaves can share one lane.

The frame runs as follows:
- One lead-in tick with the select line active.
- Two ticks per data bit, so the serial clock runs at half the pattern clock.
- One trailing tick with the select line still active.

The waveform follows mode 0: the clock idles low, and data changes only while the clock is low. Because of this, a slave that samples on the rising edge also sees the final bit while it is still selected.

Top module: `spi_pattern_gen`

## Requirements
- R1: During a frame, output bit `pos_mosi` carries the data wire, bit `pos_clk` carries the serial clock, and bit `pos_ss[3j+2:3j]` carries the select line of slave j. Every other output bit is 0.
- R2: While not busy, with a legal placement, every select bit is 1, the clock and data bits are 0, and `pat_valid`, `busy` and `done` are 0. This includes the state after reset.
- R3: A start is accepted when all of the following hold: the block is idle, `cfg_err` is 0, and `len_bits` is in 1..MAX_BITS. From the next cycle, `busy` and `pat_valid` are 1. The first word is the lead-in tick: the selected slave's select bit is 0, and the clock and data bits are 0.
- R4: Each data bit occupies two consecutive ticks. On the first tick the clock bit is 0; on the second it is 1. The data bit is the same on both ticks. Bits are sent most significant first, from payload bit `len_bits-1` down to bit 0. Payload bits at or above `len_bits` are never sent.
- R5: After the last data bit comes one trailing tick: select still 0, clock 0, data 0. `pat_valid` is 1 for exactly 2*len_bits+2 cycles.
- R6: `done` is 1 for exactly one cycle: the cycle right after the trailing tick, in which `busy` and `pat_valid` are already 0.
- R7: A start strobe that arrives while busy is ignored. The running frame continues unchanged.
- R8: If any two of the data, clock and select positions are equal, `cfg_err` is 1 and a start is refused: `busy` and `pat_valid` stay 0.
- R9: A start with `len_bits` equal to 0 or greater than MAX_BITS is refused.
- R10: Payload, length, slave index and line positions are captured when a start is accepted. Changing them during a frame does not alter that frame.
- R11: Only the slave named by `ss_sel` has its select bit driven low. All other select bits stay 1 for the whole frame.
- R12: The data bit never changes in the same tick in which the clock bit is 1. The clock is low during the lead-in and trailing ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pattern clock, one output word per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a frame |
| payload | input | 32 | Data to send, right-aligned |
| len_bits | input | 6 | Number of payload bits to send (1..32) |
| ss_sel | input | 1 | Index of the slave to select |
| pos_mosi | input | 3 | Output bit carrying the data wire |
| pos_clk | input | 3 | Output bit carrying the serial clock |
| pos_ss | input | 6 | Output bit of each slave's select line, 3 bits per slave |
| pat_word | output | 8 | Pattern word for the current tick |
| pat_valid | output | 1 | Word belongs to a frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the trailing tick |
| cfg_err | output | 1 | Line placement has a collision |

## Verification
The hardest case to reach from the ports is a change to the live placement, payload and slave index in the middle of a frame, together with a fresh start strobe. Only captured state keeps such a frame intact. The stimulus does this at a chosen tick of a table-driven transaction. It swaps the data and clock positions, inverts the payload, flips the slave and pulses start. It holds the altered inputs until the final tick and then restores them. The bench then expects the words computed from the original request.

// File: rtl/spi_pat_pkg.sv
`timescale 1ns/1ps
package spi_pat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_BITS = 2'd2,
    ST_TAIL = 2'd3
  } seq_st_e;

  // Ticks in one frame: lead-in, two per bit, trailing.
  function automatic int unsigned frame_ticks(input int unsigned nbits);
    return 2 * nbits + 2;
  endfunction

  // Length accepted for a frame.
  function automatic logic len_legal(input int unsigned nbits, input int unsigned maxb);
    return (nbits != 0) && (nbits <= maxb);
  endfunction

endpackage

// File: rtl/spi_pat_cfgchk.sv
`timescale 1ns/1ps
module spi_pat_cfgchk #(
  parameter int NUM_SS = 2,
  parameter int OUT_W  = 8,
  parameter int POS_W  = 3,
  parameter int SEL_W  = 1
) (
  input  logic [POS_W-1:0]        pos_mosi,
  input  logic [POS_W-1:0]        pos_clk,
  input  logic [NUM_SS*POS_W-1:0] pos_ss,
  input  logic [SEL_W-1:0]        ss_sel,
  output logic                    bad
);
  localparam int NL = NUM_SS + 2;

  logic [POS_W-1:0] lane [NL];
  logic             clash;
  logic             range_bad;
  logic             sel_bad;

  always_comb begin
    lane[0] = pos_mosi;
    lane[1] = pos_clk;
    for (int j = 0; j < NUM_SS; j++) lane[j+2] = pos_ss[j*POS_W +: POS_W];
  end

  always_comb begin
    clash     = 1'b0;
    range_bad = 1'b0;
    for (int a = 0; a < NL; a++) begin
      if (32'(lane[a]) >= OUT_W) range_bad = 1'b1;
      for (int b = a + 1; b < NL; b++)
        if (lane[a] == lane[b]) clash = 1'b1;
    end
  end

  generate
    if ((1 << SEL_W) > NUM_SS) begin : g_selchk
      assign sel_bad = (32'(ss_sel) >= NUM_SS);
    end else begin : g_nosel
      assign sel_bad = 1'b0;
    end
  endgenerate

  assign bad = clash | range_bad | sel_bad;

  // R8: equal data and clock positions must always be reported
  always_comb a_r8_clash_flag: assert (!(pos_mosi == pos_clk) || bad);

endmodule

// File: rtl/spi_pat_seq.sv
`timescale 1ns/1ps
module spi_pat_seq
  import spi_pat_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MAX_BITS-1:0] payload,
  input  logic [LEN_W-1:0]    len_bits,
  input  logic                cfg_bad,
  output logic                accept,
  output logic                busy,
  output logic                done,
  output logic                mosi_bit,
  output logic                sclk_bit,
  output logic                edge_tick
);
  localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
  localparam int CNT_W = $clog2(2 * MAX_BITS + 3);

  seq_st_e             st;
  logic [IDX_W-1:0]    idx;
  logic                phase;
  logic [MAX_BITS-1:0] data_q;
  logic [LEN_W-1:0]    len_q;
  logic [CNT_W-1:0]    tick_cnt;
  logic                len_ok;

  assign len_ok = len_legal(32'(len_bits), MAX_BITS);
  assign accept = start && (st == ST_IDLE) && !cfg_bad && len_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      phase    <= 1'b0;
      data_q   <= '0;
      len_q    <= '0;
      tick_cnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st != ST_IDLE) tick_cnt <= tick_cnt + 1'b1;
      unique case (st)
        ST_IDLE: if (accept) begin
          st       <= ST_LEAD;
          data_q   <= payload;
          len_q    <= len_bits;
          idx      <= IDX_W'(len_bits - 1'b1);
          phase    <= 1'b0;
          tick_cnt <= '0;
        end
        ST_LEAD: st <= ST_BITS;
        ST_BITS: begin
          phase <= ~phase;
          if (phase) begin
            if (idx == '0) st <= ST_TAIL;
            else           idx <= idx - 1'b1;
          end
        end
        ST_TAIL: begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign sclk_bit  = (st == ST_BITS) && phase;
  assign mosi_bit  = (st == ST_BITS) ? data_q[idx] : 1'b0;
  assign edge_tick = (st == ST_BITS) && !phase && (idx == '0);

  // R6: done lasts one cycle and follows the trailing tick
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TAIL) |=> (done && !busy));
  // R3: an accepted start makes the block busy next cycle
  a_r3_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !sclk_bit && !mosi_bit));
  // R8 / R9: refused starts leave the block idle
  a_r8_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cfg_bad) |=> !busy);
  a_r9_len_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !len_ok) |=> !busy);
  // R12: data held while the clock is high; clock low at lead-in and tail
  a_r12_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_bit |-> (mosi_bit == $past(mosi_bit)));
  a_r12_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LEAD || st == ST_TAIL) |-> !sclk_bit);
  // R5: frame length measured by a tick counter
  a_r5_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TAIL) |-> (32'(tick_cnt) + 1 == frame_ticks(32'(len_q))));

endmodule

// File: rtl/spi_pat_word.sv
`timescale 1ns/1ps
module spi_pat_word #(
  parameter int NUM_SS = 2,
  parameter int OUT_W  = 8,
  parameter int POS_W  = 3,
  parameter int SEL_W  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic                    busy,
  input  logic                    cfg_bad,
  input  logic                    mosi_bit,
  input  logic                    sclk_bit,
  input  logic [POS_W-1:0]        pos_mosi,
  input  logic [POS_W-1:0]        pos_clk,
  input  logic [NUM_SS*POS_W-1:0] pos_ss,
  input  logic [SEL_W-1:0]        ss_sel,
  output logic [OUT_W-1:0]        pat_word
);
  logic [POS_W-1:0] pm_q, pc_q;
  logic [POS_W-1:0] ps_q [NUM_SS];
  logic [SEL_W-1:0] sel_q;
  logic [POS_W-1:0] pm_u, pc_u;
  logic [POS_W-1:0] ps_u [NUM_SS];
  logic [NUM_SS-1:0] ss_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_q  <= '0;
      pc_q  <= '0;
      sel_q <= '0;
      for (int j = 0; j < NUM_SS; j++) ps_q[j] <= '0;
    end else if (accept) begin
      pm_q  <= pos_mosi;
      pc_q  <= pos_clk;
      sel_q <= ss_sel;
      for (int j = 0; j < NUM_SS; j++) ps_q[j] <= pos_ss[j*POS_W +: POS_W];
    end
  end

  // captured placement during a frame, live placement while idle
  always_comb begin
    pm_u = busy ? pm_q : pos_mosi;
    pc_u = busy ? pc_q : pos_clk;
    for (int j = 0; j < NUM_SS; j++)
      ps_u[j] = busy ? ps_q[j] : pos_ss[j*POS_W +: POS_W];
  end

  generate
    for (genvar j = 0; j < NUM_SS; j++) begin : g_ss
      assign ss_line[j] = !(busy && (sel_q == SEL_W'(j)));
    end
  endgenerate

  always_comb begin
    pat_word = '0;
    for (int j = 0; j < NUM_SS; j++) pat_word[ps_u[j]] = ss_line[j];
    pat_word[pc_u] = sclk_bit;
    pat_word[pm_u] = mosi_bit;
  end

  // R11: at most one select line active
  a_r11_one_slave: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ss_line) <= 1);
  // R2: idle word has clock and data low at the live positions
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_bad) |-> (!pat_word[pos_clk] && !pat_word[pos_mosi]));
  // R10: captured positions do not move during a frame
  a_r10_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(pm_q) && $stable(pc_q) && $stable(sel_q)));

endmodule

// File: rtl/spi_pattern_gen.sv
`timescale 1ns/1ps
module spi_pattern_gen #(
  parameter  int MAX_BITS = 32,
  parameter  int NUM_SS   = 2,
  parameter  int OUT_W    = 8,
  localparam int LEN_W    = $clog2(MAX_BITS + 1),
  localparam int POS_W    = (OUT_W > 1) ? $clog2(OUT_W) : 1,
  localparam int SEL_W    = (NUM_SS > 1) ? $clog2(NUM_SS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [MAX_BITS-1:0]     payload,
  input  logic [LEN_W-1:0]        len_bits,
  input  logic [SEL_W-1:0]        ss_sel,
  input  logic [POS_W-1:0]        pos_mosi,
  input  logic [POS_W-1:0]        pos_clk,
  input  logic [NUM_SS*POS_W-1:0] pos_ss,
  output logic [OUT_W-1:0]        pat_word,
  output logic                    pat_valid,
  output logic                    busy,
  output logic                    done,
  output logic                    cfg_err
);
  logic accept;
  logic mosi_bit;
  logic sclk_bit;
  logic edge_tick;

  spi_pat_cfgchk #(.NUM_SS(NUM_SS), .OUT_W(OUT_W), .POS_W(POS_W), .SEL_W(SEL_W)) u_chk (
    .pos_mosi (pos_mosi),
    .pos_clk  (pos_clk),
    .pos_ss   (pos_ss),
    .ss_sel   (ss_sel),
    .bad      (cfg_err)
  );

  spi_pat_seq #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .payload   (payload),
    .len_bits  (len_bits),
    .cfg_bad   (cfg_err),
    .accept    (accept),
    .busy      (busy),
    .done      (done),
    .mosi_bit  (mosi_bit),
    .sclk_bit  (sclk_bit),
    .edge_tick (edge_tick)
  );

  spi_pat_word #(.NUM_SS(NUM_SS), .OUT_W(OUT_W), .POS_W(POS_W), .SEL_W(SEL_W)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .busy     (busy),
    .cfg_bad  (cfg_err),
    .mosi_bit (mosi_bit),
    .sclk_bit (sclk_bit),
    .pos_mosi (pos_mosi),
    .pos_clk  (pos_clk),
    .pos_ss   (pos_ss),
    .ss_sel   (ss_sel),
    .pat_word (pat_word)
  );

  assign pat_valid = busy;

  // R7: a start while busy never ends or restarts the frame early
  a_r7_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done && $past(busy) && !$past(done)) |-> !accept);
  // R4: the last data bit is followed by its rising clock tick
  a_r4_last_bit_rise: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick |=> (sclk_bit && busy));

endmodule

// File: tb/sim_spi_pattern_gen.sv
`timescale 1ns/1ps
module sim_spi_pattern_gen;

  typedef struct packed {
    logic [31:0] pay;
    logic [5:0]  len;
    logic        sel;
    logic [2:0]  pm;
    logic [2:0]  pc;
    logic [2:0]  ps0;
    logic [2:0]  ps1;
    logic [7:0]  ticks;
    int          poke;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_A5C3, 6'd16, 1'b0, 3'd0, 3'd1, 3'd2, 3'd3, 8'd34, -1},
    '{32'h005A_F00F, 6'd24, 1'b1, 3'd7, 3'd4, 3'd0, 3'd5, 8'd50, 9},
    '{32'h0000_0001, 6'd1,  1'b0, 3'd3, 3'd6, 3'd1, 3'd2, 8'd4,  -1},
    '{32'h8000_0001, 6'd32, 1'b1, 3'd2, 3'd0, 3'd7, 3'd6, 8'd66, 40},
    '{32'hFFFF_FF6B, 6'd8,  1'b0, 3'd5, 3'd3, 3'd4, 3'd1, 8'd18, 2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] payload = '0;
  logic [5:0]  len_bits = 6'd8;
  logic [0:0]  ss_sel = 1'b0;
  logic [2:0]  pos_mosi = 3'd0;
  logic [2:0]  pos_clk = 3'd1;
  logic [5:0]  pos_ss = {3'd3, 3'd2};
  logic [7:0]  pat_word;
  logic        pat_valid, busy, done, cfg_err;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_pattern_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .payload(payload),
    .len_bits(len_bits), .ss_sel(ss_sel), .pos_mosi(pos_mosi),
    .pos_clk(pos_clk), .pos_ss(pos_ss), .pat_word(pat_word),
    .pat_valid(pat_valid), .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] idle_word(input vec_t v);
    logic [7:0] w = '0;
    w[v.ps0] = 1'b1;
    w[v.ps1] = 1'b1;
    return w;
  endfunction

  // word for tick t of a frame built from v
  function automatic logic [7:0] frame_word(input vec_t v, input int t);
    logic [7:0] w = '0;
    int n = int'(v.len);
    w[v.ps0] = (v.sel != 1'b0);
    w[v.ps1] = (v.sel != 1'b1);
    if (t >= 1 && t <= 2 * n) begin
      w[v.pc] = ((t - 1) % 2) == 1;
      w[v.pm] = v.pay[n - 1 - (t - 1) / 2];
    end
    return w;
  endfunction

  task automatic apply_cfg(input vec_t v);
    payload  = v.pay;
    len_bits = v.len;
    ss_sel   = v.sel;
    pos_mosi = v.pm;
    pos_clk  = v.pc;
    pos_ss   = {v.ps1, v.ps0};
  endtask

  task automatic run_frame(input vec_t v);
    int nt = int'(v.ticks);
    int vcount = 0;
    @(negedge clk);
    apply_cfg(v);
    #1;
    chk("R2", "idle word before frame", 32'(pat_word), 32'(idle_word(v)));
    chk("R2", "idle valid", 32'(pat_valid), 0);
    start = 1'b1;
    for (int t = 0; t < nt; t++) begin
      @(negedge clk);
      if (t == 0) start = 1'b0;
      if (pat_valid) vcount++;
      chk(t == 0 ? "R3" : (t == nt - 1 ? "R5" : "R4"), $sformatf("word tick %0d", t),
          32'(pat_word), 32'(frame_word(v, t)));
      chk("R3", "busy in frame", 32'(busy), 1);
      if (t == v.poke) begin
        // R7 / R10: new start and altered inputs mid-frame
        start    = 1'b1;
        payload  = ~v.pay;
        len_bits = 6'd5;
        ss_sel   = ~v.sel;
        pos_mosi = v.pc;
        pos_clk  = v.pm;
      end else if (v.poke >= 0 && t == v.poke + 1) begin
        start = 1'b0;
      end
      if (t == nt - 1) apply_cfg(v);
    end
    chk("R5", "valid tick count", vcount, nt);
    @(negedge clk);
    chk("R6", "done after tail", 32'(done), 1);
    chk("R6", "busy with done", 32'(busy), 0);
    chk("R5", "valid after tail", 32'(pat_valid), 0);
    chk("R2", "idle word after frame", 32'(pat_word), 32'(idle_word(v)));
    @(negedge clk);
    chk("R6", "done one cycle", 32'(done), 0);
  endtask

  task automatic try_refused(input string tag, input string what);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(tag, {what, " busy"}, 32'(busy), 0);
    chk(tag, {what, " valid"}, 32'(pat_valid), 0);
    @(negedge clk);
    chk(tag, {what, " still idle"}, 32'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2", "reset busy", 32'(busy), 0);
    chk("R2", "reset valid", 32'(pat_valid), 0);
    chk("R2", "reset done", 32'(done), 0);
    chk("R2", "reset word", 32'(pat_word), 32'(8'b0000_1100));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "word after reset release", 32'(pat_word), 32'(8'b0000_1100));

    // table walk: R1, R3, R4, R5, R6, R11, R12; some rows poke R7/R10
    for (int i = 0; i < NV; i++) run_frame(VECS[i]);

    // R8: data and clock on the same bit
    @(negedge clk);
    apply_cfg(VECS[0]);
    pos_clk = pos_mosi;
    #1;
    chk("R8", "cfg_err data/clock clash", 32'(cfg_err), 1);
    try_refused("R8", "clash data/clock");

    // R8: two select lines on one bit
    @(negedge clk);
    apply_cfg(VECS[0]);
    pos_ss = {3'd2, 3'd2};
    #1;
    chk("R8", "cfg_err select clash", 32'(cfg_err), 1);
    try_refused("R8", "clash select");

    // R9: illegal lengths
    @(negedge clk);
    apply_cfg(VECS[0]);
    #1;
    chk("R8", "cfg_err clear on legal map", 32'(cfg_err), 0);
    len_bits = 6'd0;
    try_refused("R9", "zero length");
    len_bits = 6'd33;
    try_refused("R9", "over-long length");

    // back-to-back: block still usable after refusals
    run_frame(VECS[2]);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    finished = 1;
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule